// File: doc/BRIEF.md
# Single-Frame Packet Mailbox

This block sits between a host register bus and a byte-wide MAC. It stores one received frame and one frame to transmit. The host empties a received frame by reading one 32-bit data window again and again. It fills a frame to transmit by writing another data window again and again. Two control/status words carry the ownership bits, the error flags and the byte lengths. The host acknowledges a frame by writing zero to the matching control word. One interrupt line combines the receive and transmit causes, and each cause has its own enable bit.

The host bus is a plain single-cycle port. `reg_rdata` is combinational from `reg_addr` during a read cycle. A read or write side effect happens at the clock edge that ends that cycle.

The register addresses, as word indices on `reg_addr`, are:
- 0: receive data.
- 1: receive control.
- 2: transmit data.
- 3: transmit control.
- 4: interrupt enable.

Every other address reads as zero.

Both MAC streams are valid/ready, and a beat transfers on a cycle where both are high.
- Receive: `rx_ready` is low for as long as a frame is held. The sender must then keep `rx_valid` and its data stable until it is accepted.
- Transmit: the block keeps `tx_valid`, `tx_data` and `tx_last` stable while `tx_ready` is low.

The storage depth, `DEPTH`, is given in words and is a parameter. Its default of 384 words holds a 1536-byte frame.

Top module: `pkt_mailbox`

## Requirements
- R1: `rx_ready` is high while no received frame is held. The beat that carries `rx_last` makes the frame held, and `rx_ready` then stays low until that frame is acknowledged.
- R2: Reading the receive control word returns the following fields:
  - bit 31: held.
  - bit 30: error. It is set if `rx_err` was seen on any beat of the frame, or if the frame overflowed.
  - bit 29: CRC error. It is set if `rx_crc_err` was seen on any beat of the frame.
  - bits 15:0: the stored byte length.
  - all other bits: zero.
- R3: While a frame is held, each read of the receive data word returns the next stored word and advances to the word after it. Data is packed big-endian, with the first byte in bits 31:24. Unused bytes of the final word read as zero, so a frame of L bytes takes ceil(L/4) reads.
- R4: Reading the receive data word while no frame is held returns zero. It does not move the read position.
- R5: Writing zero to the receive control word releases the held frame. After the release, the control word reads zero, the read position rewinds, and `rx_ready` is high in the following cycle. A nonzero write to the receive control word has no effect.
- R6: Bytes beyond 4*DEPTH are dropped. The frame's error flag is then set, and the stored length is 4*DEPTH.
- R7: While no send is in progress, writes to the transmit data word fill consecutive words from word 0. While a send is in progress, such writes are ignored.
- R8: A write to the transmit control word with bit 31 (go) set and length L in bits 15:0 starts a send of L bytes. The bytes leave big-endian from the stored words, and `tx_last` marks the final byte. Outputs hold steady while `tx_ready` is low. Lengths above 4*DEPTH are clamped.
- R9: On the final transmit beat:
  - go clears.
  - The done cause becomes pending.
  - Bit 30 takes the value of `tx_fail` on that beat.
  - Bits 15:0 keep L.
  - The write position rewinds to word 0.
  The transmit control word reads {go, err, 14 zero bits, length}.
- R10: While no send is in progress, writing zero to the transmit control word clears the done cause and the error flag. While a send is in progress, every write to the transmit control word is ignored.
- R11: The interrupt enable word uses bit 0 for the receive cause and bit 1 for the transmit-done cause, and it reads back in those bits. `irq` is high exactly when an enabled cause is pending. Masking leaves the causes pending, and they drive `irq` again once they are re-enabled.
- R12: A go write with length zero sends no beat. It marks the transmit-done cause pending at once, with the error flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (read side effects at the edge) |
| reg_addr | input | 3 | Host register word index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted when high |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the receive frame |
| rx_err | input | 1 | Receive error marker for this beat |
| rx_crc_err | input | 1 | CRC error marker for this beat |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| tx_fail | input | 1 | Send failure, sampled on the final beat |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of events are made to fall in the same cycle.

The first pair is the host's release of a held receive frame and the MAC's next frame. The MAC offers the next frame's first byte while the old frame is still held, and the bench writes zero to the receive control word while that byte waits. The check is that the waiting byte is accepted exactly one cycle after the release, and that the new frame reads back intact.

The second pair is transmit-data or transmit-control writes and a send in progress. These writes are issued during a send whose sink readiness is irregular, so some of them land on the final beat itself. The behavioural model then confirms that the stream, the lengths and the next frame's contents are unaffected.

// File: rtl/mb_pkg.sv
package mb_pkg;
  typedef enum logic [2:0] {
    REG_RX_DATA = 3'd0,
    REG_RX_CTL  = 3'd1,
    REG_TX_DATA = 3'd2,
    REG_TX_CTL  = 3'd3,
    REG_IRQ_EN  = 3'd4
  } mb_reg_e;

  localparam int LEN_FIELD_W = 16;
  localparam int BIT_OWN     = 31;  // rx held / tx go
  localparam int BIT_ERR     = 30;
  localparam int BIT_CRC     = 29;
  localparam int IRQ_RX_BIT  = 0;
  localparam int IRQ_TX_BIT  = 1;
endpackage

// File: rtl/mb_word_ram.sv
module mb_word_ram #(
  parameter int DEPTH = 384,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mb_rx_buf.sv
module mb_rx_buf import mb_pkg::*; #(
  parameter int DEPTH = 384
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  output logic                   rx_ready,
  input  logic [7:0]             rx_data,
  input  logic                   rx_last,
  input  logic                   rx_err,
  input  logic                   rx_crc_err,
  input  logic                   pop,
  input  logic                   ack,
  output logic                   held,
  output logic                   err_flag,
  output logic                   crc_flag,
  output logic [LEN_FIELD_W-1:0] len,
  output logic [31:0]            word
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CAP = DEPTH * 4;
  localparam int CW  = $clog2(CAP + 1);

  logic [CW-1:0] cnt_q, len_q;
  logic [31:0]   asm_q, asm_nxt, ram_q;
  logic          acc_err_q, acc_crc_q, acc_ovf_q;
  logic          held_q, ferr_q, fcrc_q;
  logic [AW-1:0] rd_ptr_q;
  logic          beat, room;
  logic [1:0]    lane;

  assign rx_ready = !held_q;
  assign beat     = rx_valid && !held_q;
  assign room     = (cnt_q < CW'(CAP));
  assign lane     = cnt_q[1:0];

  // Write-through packing: every beat rewrites the current word, so a
  // partial final word is already zero padded when the frame closes.
  always_comb begin
    asm_nxt = (lane == 2'd0) ? 32'd0 : asm_q;
    asm_nxt[8*(3-int'(lane)) +: 8] = rx_data;
  end

  mb_word_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (beat && room),
    .waddr (AW'(cnt_q >> 2)),
    .wdata (asm_nxt),
    .raddr (rd_ptr_q),
    .rdata (ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      len_q     <= '0;
      asm_q     <= '0;
      acc_err_q <= 1'b0;
      acc_crc_q <= 1'b0;
      acc_ovf_q <= 1'b0;
      held_q    <= 1'b0;
      ferr_q    <= 1'b0;
      fcrc_q    <= 1'b0;
      rd_ptr_q  <= '0;
    end else begin
      if (beat) begin
        if (room) begin
          asm_q <= asm_nxt;
          cnt_q <= cnt_q + 1'b1;
        end
        if (rx_last) begin
          held_q    <= 1'b1;
          len_q     <= cnt_q + CW'(room);
          ferr_q    <= acc_err_q | rx_err | acc_ovf_q | !room;
          fcrc_q    <= acc_crc_q | rx_crc_err;
          cnt_q     <= '0;
          acc_err_q <= 1'b0;
          acc_crc_q <= 1'b0;
          acc_ovf_q <= 1'b0;
        end else begin
          acc_err_q <= acc_err_q | rx_err;
          acc_crc_q <= acc_crc_q | rx_crc_err;
          acc_ovf_q <= acc_ovf_q | !room;
        end
      end
      if (ack && held_q) begin
        held_q   <= 1'b0;
        ferr_q   <= 1'b0;
        fcrc_q   <= 1'b0;
        len_q    <= '0;
        rd_ptr_q <= '0;
      end else if (pop && held_q && rd_ptr_q != AW'(DEPTH - 1)) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
    end
  end

  assign held     = held_q;
  assign err_flag = ferr_q;
  assign crc_flag = fcrc_q;
  assign len      = LEN_FIELD_W'(len_q);
  assign word     = held_q ? ram_q : 32'd0;

  a_r1_capture_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> $past(rx_valid && rx_last));
  a_r5_release_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && held_q) |=> rx_ready);
  a_r4_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !held_q) |=> $stable(rd_ptr_q));
  a_r6_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> (len_q <= CW'(CAP)));
endmodule

// File: rtl/mb_tx_buf.sv
module mb_tx_buf import mb_pkg::*; #(
  parameter int DEPTH = 384
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_word,
  input  logic                   ctl_wr,
  input  logic [31:0]            wdata,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic                   tx_last,
  input  logic                   tx_fail,
  output logic                   go,
  output logic                   done,
  output logic                   err_flag,
  output logic [LEN_FIELD_W-1:0] len
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CAP = DEPTH * 4;
  localparam int CW  = $clog2(CAP + 1);

  logic                   go_q, done_q, err_q;
  logic [CW-1:0]          len_q, idx_q, req_len;
  logic [AW:0]            wp_q;
  logic [31:0]            ram_q;
  logic                   store, beat, fin;
  logic [LEN_FIELD_W-1:0] raw_len;

  assign store   = wr_word && !go_q && (wp_q < (AW+1)'(DEPTH));
  assign beat    = go_q && tx_ready;
  assign fin     = (idx_q == len_q - 1'b1);
  assign raw_len = wdata[LEN_FIELD_W-1:0];
  assign req_len = (32'(raw_len) > CAP) ? CW'(CAP) : CW'(raw_len);

  mb_word_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (store),
    .waddr (wp_q[AW-1:0]),
    .wdata (wdata),
    .raddr (AW'(idx_q >> 2)),
    .rdata (ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
      wp_q   <= '0;
    end else begin
      if (store) wp_q <= wp_q + 1'b1;
      if (ctl_wr && !go_q) begin
        if (wdata == 32'd0) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
        end else if (wdata[BIT_OWN]) begin
          len_q <= req_len;
          idx_q <= '0;
          err_q <= 1'b0;
          if (req_len == '0) begin
            done_q <= 1'b1;
            wp_q   <= '0;
          end else begin
            go_q   <= 1'b1;
            done_q <= 1'b0;
          end
        end
      end
      if (beat) begin
        if (fin) begin
          go_q   <= 1'b0;
          done_q <= 1'b1;
          err_q  <= tx_fail;
          wp_q   <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign tx_valid = go_q;
  assign tx_last  = go_q && fin;
  assign tx_data  = ram_q[8*(3-int'(idx_q[1:0])) +: 8];
  assign go       = go_q;
  assign done     = done_q;
  assign err_flag = err_q;
  assign len      = LEN_FIELD_W'(len_q);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  a_r9_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (!tx_valid && done_q && wp_q == '0));
  a_r7_fill_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !(beat && fin)) |=> $stable(wp_q));
  a_r12_empty_go: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !go_q && wdata[BIT_OWN] && raw_len == '0) |=> (done_q && !tx_valid));
endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox import mb_pkg::*; #(
  parameter int DEPTH = 384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_err,
  input  logic        rx_crc_err,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_fail,
  output logic        irq
);
  mb_reg_e                addr_e;
  logic                   rx_pop, rx_ack, tx_word_wr, tx_ctl_wr;
  logic                   rx_held, rx_eflag, rx_cflag;
  logic [LEN_FIELD_W-1:0] rx_len, tx_len;
  logic [31:0]            rx_word;
  logic                   tx_go, tx_done, tx_eflag;
  logic [1:0]             irq_en_q;

  assign addr_e     = mb_reg_e'(reg_addr);
  assign rx_pop     = reg_rd && addr_e == REG_RX_DATA;
  assign rx_ack     = reg_wr && addr_e == REG_RX_CTL && reg_wdata == 32'd0;
  assign tx_word_wr = reg_wr && addr_e == REG_TX_DATA;
  assign tx_ctl_wr  = reg_wr && addr_e == REG_TX_CTL;

  mb_rx_buf #(.DEPTH(DEPTH)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .rx_err     (rx_err),
    .rx_crc_err (rx_crc_err),
    .pop        (rx_pop),
    .ack        (rx_ack),
    .held       (rx_held),
    .err_flag   (rx_eflag),
    .crc_flag   (rx_cflag),
    .len        (rx_len),
    .word       (rx_word)
  );

  mb_tx_buf #(.DEPTH(DEPTH)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_word  (tx_word_wr),
    .ctl_wr   (tx_ctl_wr),
    .wdata    (reg_wdata),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_fail  (tx_fail),
    .go       (tx_go),
    .done     (tx_done),
    .err_flag (tx_eflag),
    .len      (tx_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              irq_en_q <= 2'b00;
    else if (reg_wr && addr_e == REG_IRQ_EN) irq_en_q <= reg_wdata[1:0];
  end

  assign irq = (irq_en_q[IRQ_RX_BIT] && rx_held) || (irq_en_q[IRQ_TX_BIT] && tx_done);

  always_comb begin
    reg_rdata = 32'd0;
    case (addr_e)
      REG_RX_DATA: reg_rdata = rx_word;
      REG_RX_CTL:  reg_rdata = {rx_held, rx_eflag, rx_cflag, 13'd0, rx_len};
      REG_TX_CTL:  reg_rdata = {tx_go, tx_eflag, 14'd0, tx_len};
      REG_IRQ_EN:  reg_rdata = {30'd0, irq_en_q};
      default:     reg_rdata = 32'd0;
    endcase
  end

  a_r11_mask_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && addr_e == REG_IRQ_EN && reg_wdata[1:0] == 2'b00) |=> !irq);
  a_r11_cause_present: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_held || tx_done));
endmodule

// File: tb/pkt_mailbox_tb.sv
module pkt_mailbox_tb;
  localparam int DEPTH = 384;
  localparam int CAP   = DEPTH * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        rx_valid = 0, rx_ready, rx_last = 0, rx_err = 0, rx_crc_err = 0;
  logic [7:0]  rx_data = 0;
  logic        tx_valid, tx_ready = 0, tx_last, tx_fail = 0, irq;
  logic [7:0]  tx_data;

  pkt_mailbox #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err), .rx_crc_err(rx_crc_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_fail(tx_fail), .irq(irq)
  );

  int    n_cmp = 0, n_bad = 0, cycles = 0;
  bit    finished = 0;
  string phase = "reset";

  // ---------------- behavioural reference model ----------------
  byte unsigned m_rxb[$];
  bit           m_held, m_rerr, m_rcrc, m_aerr, m_acrc, m_aovf;
  int           m_rlen, m_rptr;
  logic [31:0]  m_tw [DEPTH];
  bit           m_go, m_done, m_terr;
  int           m_tlen, m_tidx, m_wptr;
  logic [1:0]   m_en;

  task automatic model_reset();
    m_rxb.delete();
    m_held = 0; m_rerr = 0; m_rcrc = 0; m_aerr = 0; m_acrc = 0; m_aovf = 0;
    m_rlen = 0; m_rptr = 0;
    m_go = 0; m_done = 0; m_terr = 0; m_tlen = 0; m_tidx = 0; m_wptr = 0; m_en = 0;
  endtask

  task automatic model_step();
    bit held0, go0, room;
    int l;
    held0 = m_held;
    go0   = m_go;
    if (rx_valid && !held0) begin
      room = (m_rxb.size() < CAP);
      if (room) m_rxb.push_back(rx_data);
      if (rx_last) begin
        m_held = 1; m_rlen = m_rxb.size();
        m_rerr = m_aerr | rx_err | m_aovf | !room;
        m_rcrc = m_acrc | rx_crc_err;
        m_aerr = 0; m_acrc = 0; m_aovf = 0;
      end else begin
        m_aerr |= rx_err; m_acrc |= rx_crc_err; m_aovf |= !room;
      end
    end
    if (reg_rd && reg_addr == 3'd0 && held0 && m_rptr != DEPTH - 1) m_rptr++;
    if (reg_wr && reg_addr == 3'd1 && reg_wdata == 0 && held0) begin
      m_held = 0; m_rxb.delete(); m_rptr = 0; m_rlen = 0; m_rerr = 0; m_rcrc = 0;
    end
    if (reg_wr && reg_addr == 3'd2 && !go0 && m_wptr < DEPTH) begin
      m_tw[m_wptr] = reg_wdata; m_wptr++;
    end
    if (reg_wr && reg_addr == 3'd3 && !go0) begin
      if (reg_wdata == 0) begin
        m_done = 0; m_terr = 0;
      end else if (reg_wdata[31]) begin
        l = int'(reg_wdata[15:0]);
        if (l > CAP) l = CAP;
        m_tlen = l; m_tidx = 0; m_terr = 0;
        if (l == 0) begin m_done = 1; m_wptr = 0; end
        else begin m_go = 1; m_done = 0; end
      end
    end
    if (go0 && tx_ready) begin
      if (m_tidx == m_tlen - 1) begin
        m_go = 0; m_done = 1; m_terr = tx_fail; m_wptr = 0;
      end else m_tidx++;
    end
    if (reg_wr && reg_addr == 3'd4) m_en = reg_wdata[1:0];
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] w;
    int idx;
    w = 0;
    case (a)
      3'd0: if (m_held) begin
        for (int k = 0; k < 4; k++) begin
          idx = m_rptr * 4 + k;
          if (idx < m_rxb.size()) w[8*(3-k) +: 8] = m_rxb[idx];
        end
      end
      3'd1: w = {m_held, m_rerr, m_rcrc, 13'd0, 16'(m_rlen)};
      3'd3: w = {m_go, m_terr, 14'd0, 16'(m_tlen)};
      3'd4: w = {30'd0, m_en};
      default: w = 0;
    endcase
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", req, phase, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    logic [7:0] eb;
    string rtag;
    if (rst_n && !finished) begin
      chk("R1", 32'(rx_ready), 32'(!m_held));
      chk("R8", 32'(tx_valid), 32'(m_go));
      chk("R8", 32'(tx_last), 32'(m_go && m_tidx == m_tlen - 1));
      if (m_go) begin
        eb = m_tw[m_tidx / 4][8*(3 - (m_tidx % 4)) +: 8];
        chk("R8", 32'(tx_data), 32'(eb));
      end
      chk("R11", 32'(irq), 32'((m_en[0] && m_held) || (m_en[1] && m_done)));
      if (reg_rd) begin
        case (reg_addr)
          3'd0: rtag = m_held ? "R3" : "R4";
          3'd1: rtag = "R2";
          3'd3: rtag = "R9";
          3'd4: rtag = "R11";
          default: rtag = "R4";
        endcase
        chk(rtag, reg_rdata, exp_rd(reg_addr));
      end
    end
  end

  // irregular sink readiness
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= lfsr[0] | lfsr[3];
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] q);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); q = reg_rdata;
    tick();
    reg_rd = 0;
  endtask

  task automatic rx_frame(input int n, input int seed, input bit err_mid, input bit crc_end);
    for (int i = 0; i < n; i++) begin
      bit acc;
      rx_valid = 1; rx_data = 8'(seed + i * 7); rx_last = (i == n - 1);
      rx_err = err_mid && (i == n / 2); rx_crc_err = crc_end && (i == n - 1);
      do begin
        @(negedge clk); acc = rx_ready;
        tick();
      end while (!acc);
    end
    rx_valid = 0; rx_last = 0; rx_err = 0; rx_crc_err = 0;
  endtask

  task automatic tx_wait();
    bit v;
    do begin
      @(negedge clk); v = tx_valid;
      tick();
    end while (v);
  endtask

  logic [31:0] q;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", 32'(rx_ready), 32'd1);
    chk("R8", 32'(tx_valid), 32'd0);
    chk("R11", 32'(irq), 32'd0);
    tick();

    phase = "R11 enable";
    wr(3'd4, 32'd3);
    rd(3'd4, q); chk("R11", q, 32'd3);

    phase = "R1 R3 70-byte frame";
    rx_frame(70, 16, 0, 0);
    rd(3'd1, q); chk("R2", q, {1'b1, 2'b00, 13'd0, 16'd70});
    for (int w = 0; w < 18; w++) begin
      rd(3'd0, q);
      if (w == 17) chk("R3", q[15:0], 32'd0);
      if (w == 0)  chk("R3", q, {8'd16, 8'd23, 8'd30, 8'd37});
    end

    phase = "R5 nonzero write";
    wr(3'd1, 32'h0000_0001);
    rd(3'd1, q); chk("R5", 32'(q[31]), 32'd1);
    wr(3'd1, 32'd0);
    rd(3'd1, q); chk("R5", q, 32'd0);
    phase = "R4 empty reads";
    rd(3'd0, q); chk("R4", q, 32'd0);
    rd(3'd0, q); chk("R4", q, 32'd0);

    phase = "R2 flags";
    rx_frame(5, 200, 1, 1);
    rd(3'd1, q); chk("R2", q, {3'b111, 13'd0, 16'd5});
    phase = "R11 mask";
    wr(3'd4, 32'd0);
    @(negedge clk); chk("R11", 32'(irq), 32'd0); tick();
    wr(3'd4, 32'd1);
    @(negedge clk); chk("R11", 32'(irq), 32'd1); tick();
    rd(3'd0, q); rd(3'd0, q);

    phase = "R5 release with next frame waiting";
    fork
      rx_frame(6, 90, 0, 0);
      begin tick(); tick(); wr(3'd1, 32'd0); end
    join
    rd(3'd1, q); chk("R1", q, {1'b1, 2'b00, 13'd0, 16'd6});
    rd(3'd0, q); chk("R3", q, {8'd90, 8'd97, 8'd104, 8'd111});
    rd(3'd0, q); chk("R3", q, {8'd118, 8'd125, 16'd0});
    wr(3'd1, 32'd0);

    phase = "R8 send 18 bytes";
    wr(3'd4, 32'd2);
    for (int w = 0; w < 5; w++) wr(3'd2, 32'h1122_3344 + 32'(w) * 32'h0101_0101);
    wr(3'd3, 32'h8000_0012);
    phase = "R7 R10 writes while busy";
    wr(3'd2, 32'hDEAD_BEEF);
    wr(3'd3, 32'd0);
    wr(3'd3, 32'h8000_0004);
    wr(3'd2, 32'hCAFE_F00D);
    tx_wait();
    rd(3'd3, q); chk("R9", q, {2'b00, 14'd0, 16'd18});
    chk("R11", 32'(irq), 32'd1);
    wr(3'd3, 32'd0);
    @(negedge clk); chk("R10", 32'(irq), 32'd0); tick();

    phase = "R7 R9 failed send";
    tx_fail = 1;
    wr(3'd2, 32'hA1B2_C3D4);
    wr(3'd3, 32'h8000_0003);
    tx_wait();
    tx_fail = 0;
    rd(3'd3, q); chk("R9", q, {2'b01, 14'd0, 16'd3});
    wr(3'd3, 32'd0);
    rd(3'd3, q); chk("R10", 32'(q[30]), 32'd0);

    phase = "R12 zero length";
    wr(3'd3, 32'h8000_0000);
    @(negedge clk); chk("R12", 32'(irq), 32'd1); chk("R12", 32'(tx_valid), 32'd0); tick();
    rd(3'd3, q); chk("R12", q, 32'd0);
    wr(3'd3, 32'd0);

    phase = "R6 overflow";
    wr(3'd4, 32'd1);
    rx_frame(CAP + 4, 3, 0, 0);
    rd(3'd1, q); chk("R6", q, {3'b110, 13'd0, 16'(CAP)});
    wr(3'd1, 32'd0);

    phase = "R8 single byte";
    wr(3'd2, 32'h5A00_0000);
    wr(3'd3, 32'h8000_0001);
    tx_wait();
    rd(3'd3, q); chk("R9", q, {2'b00, 14'd0, 16'd1});

    repeat (4) tick();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule